// File: doc/BRIEF.md
# Program Word Readback Controller

This block lets an 8-bit microcontroller core read any word of its 14-bit program memory through five byte-wide registers. Software loads a two-byte word address and then writes the control register with both the start bit and the program-space bit set. The block lets the next instruction slot run normally. On the slot after that it takes the program memory port and fetches the word. It raises a squash line so the core throws away that slot's instruction. One cycle later the block copies the word into two data registers, where software picks it up as a low byte and a high byte.

The core appears here as an instruction-slot strobe and a squash output. The program memory is a synchronous array with one cycle of read latency, attached through a simple address, read-enable and data port. Erase and write sequencing, data EEPROM access and the core itself lie outside this block. A write request made while the program space is selected is dropped on the spot.

Register map, at the 3-bit select: 0 address low byte, 1 address high byte, 2 control, 3 data low byte, 4 data high byte; 5 to 7 read as 0. The control register has bit 0 as the start (read) bit, bit 1 as the write request bit and bit 7 as the program-space select; bits 6 to 2 read as 0.

Top module: `prog_mem_reader`

## Requirements
- R1: The fetch address is {high register, low register}. The high register keeps only its low ADDR_W-8 bits (4 at the default), and its upper bits read back as 0. The address is captured in the cycle of the triggering control write.
- R2: A read starts only when one control write carries both bit 0 = 1 and bit 7 = 1. Bit 0 written with bit 7 = 0 starts nothing, and bit 0 reads back as 0.
- R3: The first instruction slot after the trigger cycle passes without squash. On the second slot, squash and the memory read enable are high for exactly that cycle, and the address port carries the captured address. A slot strobe in the trigger cycle itself does not count.
- R4: The fetched word is written into the data registers at the end of the cycle that follows the fetch slot. The data low register holds bits 7:0 and the data high register holds bits 13:8, with its top two bits reading 0.
- R5: The data registers keep their value until the next read completes or software writes them. A software write to the data high register stores only the low 6 bits. If a latch and a software write meet in the same cycle, the latch wins.
- R6: A control write with bit 1 = 1 and bit 7 = 1 leaves bit 1 reading 0 and causes no fetch and no squash. With bit 7 = 0, bit 1 is stored and reads back as 1.
- R7: Control bit 0 reads 1 from the cycle after the trigger until the word is latched, and it reads 0 from the cycle after the latch.
- R8: While a read is pending, a further trigger write is ignored and changes to the address registers do not change the address that is fetched.
- R9: After reset all registers read 0 and squash and the memory read enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotStb | input | 1 | High in a cycle that begins an instruction slot |
| regWrEn | input | 1 | Register write strobe from the core |
| regWrSel | input | 3 | Register select for the write |
| regWrData | input | 8 | Write data |
| regRdSel | input | 3 | Register select for readback |
| regRdData | output | 8 | Readback data of the selected register |
| squash | output | 1 | Tells the core to discard this slot's instruction |
| memRe | output | 1 | Program memory read enable |
| memAddr | output | ADDR_W | Program memory word address |
| memData | input | DATA_W | Program memory word, valid one cycle after memRe |

## Verification
The bench builds the block with the default 12-bit address and 14-bit word. At these values the high address register has four spare bits and the data high register has two, so the masking of both sides can be seen at the ports, and the extreme addresses 0x000 and 0xFFF can be reached in only a few writes. The bench changes the slot strobe period between 1, 3 and 4 cycles. This moves the fetch slot relative to the trigger, and with a period of 1 it also places a slot strobe inside the trigger cycle.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_ADDR_LO = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ADDR_HI = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL    = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DATA_LO = 3'd3;
  localparam logic [SEL_W-1:0] SEL_DATA_HI = 3'd4;

  localparam int CTRL_RD   = 0;
  localparam int CTRL_WR   = 1;
  localparam int CTRL_PROG = 7;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WAIT,
    PH_FETCH,
    PH_LATCH
  } phase_e;

  typedef struct packed {
    logic captureAddr;
    logic issueFetch;
    logic latchData;
  } strobe_t;
endpackage

// File: rtl/pmr_ctrl.sv
module pmr_ctrl
  import pmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             slotStb,
  input  logic             regWrEn,
  input  logic [SEL_W-1:0] regWrSel,
  input  logic             wrRdBit,
  input  logic             wrWrBit,
  input  logic             wrProgBit,
  output strobe_t          strobes,
  output logic             squash,
  output logic             rdBit,
  output logic             wrBit,
  output logic             progSel
);
  phase_e phase, phaseNext;
  logic   ctrlWr;
  logic   busy;
  logic   trigger;

  assign ctrlWr  = regWrEn && (regWrSel == SEL_CTRL);
  assign busy    = (phase != PH_IDLE);
  assign trigger = ctrlWr && wrRdBit && wrProgBit && !busy;

  always_comb begin
    strobes             = '0;
    strobes.captureAddr = trigger;
    strobes.issueFetch  = (phase == PH_FETCH) && slotStb;
    strobes.latchData   = (phase == PH_LATCH);
  end

  assign squash = strobes.issueFetch;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:  if (trigger) phaseNext = PH_WAIT;
      PH_WAIT:  if (slotStb) phaseNext = PH_FETCH;
      PH_FETCH: if (slotStb) phaseNext = PH_LATCH;
      PH_LATCH: phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      rdBit   <= 1'b0;
      wrBit   <= 1'b0;
      progSel <= 1'b0;
    end else begin
      phase <= phaseNext;
      if (ctrlWr) begin
        progSel <= wrProgBit;
        wrBit   <= wrWrBit && !wrProgBit;
      end
      if (strobes.latchData) begin
        rdBit <= 1'b0;
      end else if (trigger) begin
        rdBit <= 1'b1;
      end
    end
  end

  // R7: the start bit drops once the word is in the data registers
  a_r7_rd_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchData |=> !rdBit);

  // R6: a write request with program space selected never sticks
  a_r6_wr_cancel: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrWrBit && wrProgBit) |=> !wrBit);

  // R3: the squash pulse lasts a single cycle
  a_r3_squash_single: assert property (@(posedge clk) disable iff (!rstN)
    squash |=> !squash);

  // R7: a pending read shows the start bit as set
  a_r7_rd_pending: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueFetch |-> rdBit);
endmodule

// File: rtl/pmr_datapath.sv
module pmr_datapath
  import pmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regWrSel,
  input  logic [7:0]        regWrData,
  input  strobe_t           strobes,
  input  logic              rdBit,
  input  logic              wrBit,
  input  logic              progSel,
  input  logic [SEL_W-1:0]  regRdSel,
  output logic [7:0]        regRdData,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData
);
  localparam int HI_A_W = ADDR_W - 8;
  localparam int HI_D_W = DATA_W - 8;

  logic [7:0]        addrLo;
  logic [HI_A_W-1:0] addrHi;
  logic [ADDR_W-1:0] capAddr;
  logic [7:0]        dataLo;
  logic [HI_D_W-1:0] dataHi;
  logic [7:0]        addrHiView;
  logic [7:0]        dataHiView;
  logic [7:0]        ctrlView;

  // Pad the narrow high registers to a full byte for readback
  generate
    if (HI_A_W < 8) begin : g_pad_addr
      assign addrHiView = {{(8-HI_A_W){1'b0}}, addrHi};
    end else begin : g_full_addr
      assign addrHiView = addrHi;
    end
    if (HI_D_W < 8) begin : g_pad_data
      assign dataHiView = {{(8-HI_D_W){1'b0}}, dataHi};
    end else begin : g_full_data
      assign dataHiView = dataHi;
    end
  endgenerate

  always_comb begin
    ctrlView            = '0;
    ctrlView[CTRL_RD]   = rdBit;
    ctrlView[CTRL_WR]   = wrBit;
    ctrlView[CTRL_PROG] = progSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLo  <= '0;
      addrHi  <= '0;
      capAddr <= '0;
      dataLo  <= '0;
      dataHi  <= '0;
    end else begin
      if (strobes.captureAddr) begin
        capAddr <= {addrHi, addrLo};
      end
      if (regWrEn && regWrSel == SEL_ADDR_LO) begin
        addrLo <= regWrData;
      end
      if (regWrEn && regWrSel == SEL_ADDR_HI) begin
        addrHi <= regWrData[HI_A_W-1:0];
      end
      if (strobes.latchData) begin
        dataLo <= memData[7:0];
        dataHi <= memData[DATA_W-1:8];
      end else begin
        if (regWrEn && regWrSel == SEL_DATA_LO) begin
          dataLo <= regWrData;
        end
        if (regWrEn && regWrSel == SEL_DATA_HI) begin
          dataHi <= regWrData[HI_D_W-1:0];
        end
      end
    end
  end

  assign memAddr = capAddr;

  always_comb begin
    unique case (regRdSel)
      SEL_ADDR_LO: regRdData = addrLo;
      SEL_ADDR_HI: regRdData = addrHiView;
      SEL_CTRL:    regRdData = ctrlView;
      SEL_DATA_LO: regRdData = dataLo;
      SEL_DATA_HI: regRdData = dataHiView;
      default:     regRdData = '0;
    endcase
  end

  // R4: the latch always comes in the cycle after the fetch
  a_r4_latch_follows_fetch: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueFetch |=> strobes.latchData);

  // R4: the data registers take the word that the memory returned
  a_r4_latch_value: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchData |=> (dataLo == $past(memData[7:0])));

  // R5: with no latch and no software write, the low data byte holds
  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.latchData && !(regWrEn && regWrSel == SEL_DATA_LO)) |=> $stable(dataLo));

  // R8: the fetch address moves only at a trigger
  a_r8_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureAddr |=> $stable(memAddr));
endmodule

// File: rtl/prog_mem_reader.sv
module prog_mem_reader
  import pmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotStb,
  input  logic              regWrEn,
  input  logic [2:0]        regWrSel,
  input  logic [7:0]        regWrData,
  input  logic [2:0]        regRdSel,
  output logic [7:0]        regRdData,
  output logic              squash,
  output logic              memRe,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData
);
  strobe_t strobes;
  logic    rdBit;
  logic    wrBit;
  logic    progSel;

  pmr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .slotStb   (slotStb),
    .regWrEn   (regWrEn),
    .regWrSel  (regWrSel),
    .wrRdBit   (regWrData[CTRL_RD]),
    .wrWrBit   (regWrData[CTRL_WR]),
    .wrProgBit (regWrData[CTRL_PROG]),
    .strobes   (strobes),
    .squash    (squash),
    .rdBit     (rdBit),
    .wrBit     (wrBit),
    .progSel   (progSel)
  );

  pmr_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrSel  (regWrSel),
    .regWrData (regWrData),
    .strobes   (strobes),
    .rdBit     (rdBit),
    .wrBit     (wrBit),
    .progSel   (progSel),
    .regRdSel  (regRdSel),
    .regRdData (regRdData),
    .memAddr   (memAddr),
    .memData   (memData)
  );

  assign memRe = strobes.issueFetch;

  // R3: squash and the memory read come together, always on a slot
  a_r3_squash_with_read: assert property (@(posedge clk) disable iff (!rstN)
    squash |-> (memRe && slotStb));
endmodule

// File: tb/prog_mem_reader_tb.sv
`timescale 1ns/1ps
module prog_mem_reader_tb;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 14;
  parameter int ROM_SEED = 'h2b5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              slotStb = 1'b0;
  logic              regWrEn = 1'b0;
  logic [2:0]        regWrSel = '0;
  logic [7:0]        regWrData = '0;
  logic [2:0]        regRdSel = '0;
  logic [7:0]        regRdData;
  logic              squash;
  logic              memRe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData = '0;

  prog_mem_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .slotStb(slotStb), .regWrEn(regWrEn),
    .regWrSel(regWrSel), .regWrData(regWrData), .regRdSel(regRdSel),
    .regRdData(regRdData), .squash(squash), .memRe(memRe),
    .memAddr(memAddr), .memData(memData)
  );

  always #2.5 clk = ~clk;

  function automatic logic [DATA_W-1:0] romWord(input int a);
    return DATA_W'((a * 73 + ROM_SEED) ^ (a << 5) ^ (a >> 2));
  endfunction

  // Synchronous program memory, one cycle of latency
  always @(posedge clk) if (memRe) memData <= romWord(int'(memAddr));

  // Behavioural reference state
  int mALo, mAHi, mProg, mWr, mRd, mDLo, mDHi, mCap;
  int slotsSeen;      // -1: no read pending; else slots counted since trigger
  bit latchDue;
  int nCmp = 0, nBad = 0, cyc = 0, slotPeriod = 1;
  string tag = "R9";
  bit done = 1'b0;

  task automatic chk(input string what, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int expRd(input int sel);
    case (sel)
      0: return mALo;
      1: return mAHi;
      2: return (mProg << 7) | (mWr << 1) | mRd;
      3: return mDLo;
      4: return mDHi;
      default: return 0;
    endcase
  endfunction

  task automatic step(input bit we, input int sel, input int d);
    bit slot, trig, busy, fetch, latch;
    int word;
    @(negedge clk);
    slot = ((cyc % slotPeriod) == 0);
    slotStb = slot; regWrEn = we; regWrSel = 3'(sel); regWrData = 8'(d);
    regRdSel = 3'(cyc % 8);
    #1;
    busy  = (slotsSeen >= 0) || latchDue;
    fetch = (slotsSeen == 1) && slot;
    latch = latchDue;
    trig  = we && sel == 2 && d[0] && d[7] && !busy;
    chk("squash", int'(squash), int'(fetch));
    chk("memRe", int'(memRe), int'(fetch));
    if (fetch) chk("memAddr", int'(memAddr), mCap);
    chk($sformatf("readback sel %0d", cyc % 8), int'(regRdData), expRd(cyc % 8));
    // reference update for the coming edge
    if (latch) begin
      word = int'(romWord(mCap));
      mDLo = word & 'hff; mDHi = (word >> 8) & 'h3f; mRd = 0; latchDue = 0;
    end
    if (fetch) begin slotsSeen = -1; latchDue = 1; end
    else if (slotsSeen >= 0 && slot) slotsSeen++;
    if (trig) begin mCap = (mAHi << 8) | mALo; slotsSeen = 0; mRd = 1; end
    if (we) begin
      case (sel)
        0: mALo = d & 'hff;
        1: mAHi = d & 'h0f;
        2: begin mProg = d[7]; mWr = (d[1] && !d[7]) ? 1 : 0; end
        3: if (!latch) mDLo = d & 'hff;
        4: if (!latch) mDHi = d & 'h3f;
        default: ;
      endcase
    end
    cyc++;
  endtask

  task automatic wrReg(input int sel, input int d); step(1'b1, sel, d); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0);
  endtask
  task automatic readAt(input int addr);
    wrReg(0, addr & 'hff);
    wrReg(1, addr >> 8);
    wrReg(2, 'h81);
    idle(16);
  endtask

  initial begin
    mALo = 0; mAHi = 0; mProg = 0; mWr = 0; mRd = 0; mDLo = 0; mDHi = 0; mCap = 0;
    slotsSeen = -1; latchDue = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    tag = "R9"; idle(8);

    // R1 R3 R4 R7: plain read, slot every cycle (slot also in trigger cycle)
    tag = "R3"; slotPeriod = 1; readAt('h123);
    tag = "R4"; slotPeriod = 1; readAt('h000);
    // R3: sparse slots
    tag = "R3"; slotPeriod = 3; readAt('h456);
    tag = "R7"; slotPeriod = 4; readAt('h9a7);
    // R1: high register upper bits ignored, top address
    tag = "R1"; slotPeriod = 1;
    wrReg(1, 'hff); wrReg(0, 'hff); idle(8);
    wrReg(2, 'h81); idle(16);
    // R8: address changes and a second trigger during a pending read
    tag = "R8"; slotPeriod = 4;
    wrReg(0, 'hab); wrReg(1, 'h00); wrReg(2, 'h81);
    wrReg(0, 'h11); wrReg(1, 'h07); wrReg(2, 'h81); idle(20);
    // R2: start bit without program select
    tag = "R2"; slotPeriod = 1;
    wrReg(2, 'h01); idle(10);
    wrReg(2, 'h80); wrReg(2, 'h01); idle(10);
    // R6: write request with and without program select
    tag = "R6";
    wrReg(2, 'h82); idle(10);
    wrReg(2, 'h02); idle(9);
    wrReg(2, 'h00); idle(8);
    // R5: software writes and hold
    tag = "R5";
    wrReg(3, 'h5a); wrReg(4, 'hff); idle(16);
    readAt('h3c4);
    wrReg(4, 'h41); idle(10);
    // R5: software write in the latch cycle loses to the latch
    slotPeriod = 1;
    wrReg(0, 'h77); wrReg(1, 'h02); wrReg(2, 'h81);
    idle(2); wrReg(3, 'h99); idle(10);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule